// File: doc/BRIEF.md
# Mask-Conditioned Branch Resolution Unit

This block settles branch instructions in the execute stage of a mainframe-style pipeline. The decoder gives it an operation class, either the register form or the storage form, the register fields with the contents already read from the register file, a 12-bit displacement, the current 2-bit condition code and the address of the following instruction. One cycle later the block reports whether the branch is taken and where it goes. It also reports any register write-back, which is either the link address or the decremented count.

Three classes are handled: conditional branch under a 4-bit mask, branch with link, and branch on count. Field value 0 has a special role. In register form, a target field of 0 suppresses the branch but leaves any write-back in place. A mask of 0 never branches. In storage form, a base or index field of 0 adds nothing to the address.

Top module: `branch_resolve`

## Requirements
- R1: Outputs are registered: an input accepted with `in_valid` high produces `out_valid` high for exactly the next cycle. With `in_valid` low the next cycle shows `out_valid`, `out_taken` and `out_wb_en` low. Reset clears every output to zero.
- R2: Class code 0 is the conditional branch, and `in_r1` holds its 4-bit mask. Mask bit 3 stands for condition code 0, bit 2 for code 1, bit 1 for code 2 and bit 0 for code 3. The branch is taken when the bit for the current code is set, so a mask of 0 is never taken.
- R3: In register form (`in_rx` = 0), a target field `in_r2` of 0 never gives a taken branch, whatever the class, mask or count.
- R4: Class code 1 is branch with link. It always writes the next-instruction address, zero-extended to 32 bits, to register `in_r1`. This includes register form with target field 0. Otherwise it is always taken.
- R5: Class code 2 is branch on count. It always writes `in_r1_val - 1`, modulo 2^32, to register `in_r1`. It is taken only when that result is nonzero, and never under R3.
- R6: In storage form (`in_rx` = 1), the target is base contents plus index contents plus the unsigned displacement, kept to the low 24 bits. The base field is `in_b2` and the index field is `in_r2`. A field of 0 contributes zero.
- R7: In register form, the target is the low 24 bits of the contents of register `in_r2`.
- R8: `out_target` reads zero whenever `out_taken` is low. `out_wb_en` is high only for classes 1 and 2. Class code 3 is a no-operation: it is never taken and never writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Branch operation present this cycle |
| in_kind | input | 2 | Class: 0 conditional, 1 link, 2 count, 3 no-op |
| in_rx | input | 1 | 1 = storage form, 0 = register form |
| in_r1 | input | 4 | Mask (class 0) or link/count register number |
| in_r1_val | input | 32 | Contents of register in_r1 (count value) |
| in_r2 | input | 4 | Target register (register form) or index register (storage form) |
| in_r2_val | input | 32 | Contents of register in_r2 |
| in_b2 | input | 4 | Base register number (storage form) |
| in_b2_val | input | 32 | Contents of register in_b2 |
| in_disp | input | 12 | Unsigned displacement |
| in_cc | input | 2 | Current condition code |
| in_next_addr | input | 24 | Address of the following instruction |
| out_valid | output | 1 | Result strobe, one cycle |
| out_taken | output | 1 | Branch taken |
| out_target | output | 24 | Target address when taken, else zero |
| out_wb_en | output | 1 | Register write-back request |
| out_wb_reg | output | 4 | Register number to write |
| out_wb_data | output | 32 | Value to write |

## Verification
The hardest cases to reach sit where field value 0 meets the counting class. The first is register form with target field 0 and a count of 1 or 0. Here the decrement must still be written, yet the branch stays not taken. The second is a count of 0 in any form: the decrement wraps to all ones, and in storage form this must count as a taken branch. The stimulus walks a directed list through every class, form, mask and condition code with the zero fields. It then runs biased random operations, in which zero fields and counts of 0, 1 and 2 come up often and operands near the top of the range force the address sum to wrap.

// File: rtl/branch_resolve.sv
module branch_resolve #(
  parameter int AW    = 24,
  parameter int DW    = 32,
  parameter int RW    = 4,
  parameter int DISPW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    in_kind,
  input  logic          in_rx,
  input  logic [RW-1:0] in_r1,
  input  logic [DW-1:0] in_r1_val,
  input  logic [RW-1:0] in_r2,
  input  logic [DW-1:0] in_r2_val,
  input  logic [RW-1:0] in_b2,
  input  logic [DW-1:0] in_b2_val,
  input  logic [DISPW-1:0] in_disp,
  input  logic [1:0]    in_cc,
  input  logic [AW-1:0] in_next_addr,
  output logic          out_valid,
  output logic          out_taken,
  output logic [AW-1:0] out_target,
  output logic          out_wb_en,
  output logic [RW-1:0] out_wb_reg,
  output logic [DW-1:0] out_wb_data
);

  localparam logic [1:0] K_COND  = 2'd0;
  localparam logic [1:0] K_LINK  = 2'd1;
  localparam logic [1:0] K_COUNT = 2'd2;

  wire rr_null = !in_rx && (in_r2 == '0);

  wire [DW-1:0] base_term = (in_b2 != '0) ? in_b2_val : '0;
  wire [DW-1:0] idx_term  = (in_r2 != '0) ? in_r2_val : '0;
  wire [DW-1:0] rx_sum    = base_term + idx_term + DW'(in_disp);
  wire [AW-1:0] eff_addr  = in_rx ? rx_sum[AW-1:0] : in_r2_val[AW-1:0];

  wire [DW-1:0] cnt_dec = in_r1_val - DW'(1);
  wire [1:0]    mask_sel = 2'd3 - in_cc;
  wire          cc_hit  = in_r1[mask_sel];

  logic          take_c;
  logic          wb_c;
  logic [DW-1:0] wb_data_c;

  always_comb begin
    take_c    = 1'b0;
    wb_c      = 1'b0;
    wb_data_c = '0;
    case (in_kind)
      K_COND:  take_c = cc_hit;
      K_LINK: begin
        take_c    = 1'b1;
        wb_c      = 1'b1;
        wb_data_c = DW'(in_next_addr);
      end
      K_COUNT: begin
        take_c    = (cnt_dec != '0);
        wb_c      = 1'b1;
        wb_data_c = cnt_dec;
      end
      default: ;
    endcase
    if (rr_null) take_c = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_taken   <= 1'b0;
      out_target  <= '0;
      out_wb_en   <= 1'b0;
      out_wb_reg  <= '0;
      out_wb_data <= '0;
    end else begin
      out_valid   <= in_valid;
      out_taken   <= in_valid && take_c;
      out_target  <= (in_valid && take_c) ? eff_addr : '0;
      out_wb_en   <= in_valid && wb_c;
      out_wb_reg  <= (in_valid && wb_c) ? in_r1 : '0;
      out_wb_data <= (in_valid && wb_c) ? wb_data_c : '0;
    end
  end

  p_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_taken && !out_wb_en));

  p_mask_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == K_COND && in_r1 == '0) |=> !out_taken);

  p_rr_null_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_rx && in_r2 == '0) |=> !out_taken);

  p_link_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == K_LINK) |=>
      (out_wb_en && out_wb_reg == $past(in_r1) &&
       out_wb_data == DW'($past(in_next_addr))));

  p_count_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == K_COUNT) |=>
      (out_wb_en && out_wb_data == $past(in_r1_val) - DW'(1)));

  p_nop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == 2'd3) |=> (!out_taken && !out_wb_en));

  p_target_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_taken |-> (out_target == '0));

endmodule

// File: tb/tb_branch_resolve.sv
module tb_branch_resolve;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_kind = '0;
  logic        in_rx = 1'b0;
  logic [3:0]  in_r1 = '0, in_r2 = '0, in_b2 = '0;
  logic [31:0] in_r1_val = '0, in_r2_val = '0, in_b2_val = '0;
  logic [11:0] in_disp = '0;
  logic [1:0]  in_cc = '0;
  logic [23:0] in_next_addr = '0;
  logic        out_valid, out_taken, out_wb_en;
  logic [23:0] out_target;
  logic [3:0]  out_wb_reg;
  logic [31:0] out_wb_data;

  always #4 clk = ~clk;

  branch_resolve dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
    .in_rx(in_rx), .in_r1(in_r1), .in_r1_val(in_r1_val), .in_r2(in_r2),
    .in_r2_val(in_r2_val), .in_b2(in_b2), .in_b2_val(in_b2_val),
    .in_disp(in_disp), .in_cc(in_cc), .in_next_addr(in_next_addr),
    .out_valid(out_valid), .out_taken(out_taken), .out_target(out_target),
    .out_wb_en(out_wb_en), .out_wb_reg(out_wb_reg), .out_wb_data(out_wb_data)
  );

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  bit          e_valid, e_taken, e_wb;
  logic [23:0] e_target;
  logic [3:0]  e_reg;
  logic [31:0] e_data;
  bit          have_exp = 0;
  logic [1:0]  last_kind;
  bit          last_rx;

  task automatic model();
    longint sum;
    longint cnt;
    bit tk = 0;
    e_valid = in_valid; e_wb = 0; e_reg = 0; e_data = 0;
    last_kind = in_kind; last_rx = in_rx;
    if (in_rx) begin
      sum = longint'(in_disp);
      if (in_b2 != 0) sum += longint'(in_b2_val);
      if (in_r2 != 0) sum += longint'(in_r2_val);
    end else sum = longint'(in_r2_val);
    if (in_kind == 0) tk = in_r1[3 - int'(in_cc)];
    else if (in_kind == 1) begin
      tk = 1; e_wb = 1; e_reg = in_r1; e_data = {8'h0, in_next_addr};
    end else if (in_kind == 2) begin
      cnt = (longint'(in_r1_val) + 64'hFFFF_FFFF) % 64'h1_0000_0000;
      tk = (cnt != 0); e_wb = 1; e_reg = in_r1; e_data = cnt[31:0];
    end
    if (!in_rx && in_r2 == 0) tk = 0;
    if (!in_valid) begin tk = 0; e_wb = 0; e_reg = 0; e_data = 0; end
    e_taken = tk;
    e_target = tk ? 24'(sum % 64'h100_0000) : 24'h0;
  endtask

  function automatic string tag_take(logic [1:0] k, bit rx);
    if (k == 3) return "R8";
    if (!rx) return (k == 0) ? "R2/R3" : (k == 1) ? "R4/R3" : "R5/R3";
    return (k == 0) ? "R2" : (k == 1) ? "R4" : "R5";
  endfunction

  task automatic compare();
    vectors++;
    if (out_valid !== e_valid) begin
      fails++; $display("FAIL R1 valid act=%0b exp=%0b", out_valid, e_valid);
    end
    if (out_taken !== e_taken) begin
      fails++; $display("FAIL %s taken act=%0b exp=%0b", tag_take(last_kind, last_rx), out_taken, e_taken);
    end
    if (out_target !== e_target) begin
      fails++; $display("FAIL %s target act=%h exp=%h", last_rx ? "R6" : "R7", out_target, e_target);
    end
    if (out_wb_en !== e_wb || out_wb_reg !== e_reg || out_wb_data !== e_data) begin
      fails++;
      $display("FAIL %s wb act=%0b/%0d/%h exp=%0b/%0d/%h",
               (last_kind == 1) ? "R4" : (last_kind == 2) ? "R5" : "R8",
               out_wb_en, out_wb_reg, out_wb_data, e_wb, e_reg, e_data);
    end
  endtask

  task automatic step();
    model();
    @(negedge clk);
    compare();
  endtask

  task automatic op(input bit v, input logic [1:0] k, input bit rx,
                    input logic [3:0] r1, input logic [31:0] r1v,
                    input logic [3:0] r2, input logic [31:0] r2v,
                    input logic [3:0] b2, input logic [31:0] b2v,
                    input logic [11:0] d, input logic [1:0] cc,
                    input logic [23:0] na);
    in_valid = v; in_kind = k; in_rx = rx; in_r1 = r1; in_r1_val = r1v;
    in_r2 = r2; in_r2_val = r2v; in_b2 = b2; in_b2_val = b2v;
    in_disp = d; in_cc = cc; in_next_addr = na;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (out_valid !== 0 || out_taken !== 0 || out_target !== 0 ||
        out_wb_en !== 0 || out_wb_reg !== 0 || out_wb_data !== 0) begin
      fails++; $display("FAIL R1 reset outputs act=%0b%0b%h%0b exp=0000",
                        out_valid, out_taken, out_target, out_wb_en);
    end
    rst_n = 1'b1;
    // R2: every mask against every condition code, storage form
    for (int m = 0; m < 16; m++)
      for (int c = 0; c < 4; c++)
        op(1, 0, 1, 4'(m), 0, 4'd5, 32'h100, 4'd6, 32'h2000, 12'h010, 2'(c), 24'h4);
    // R3: register form target field 0 for each class
    op(1, 0, 0, 4'hF, 0, 4'd0, 32'h1234, 0, 0, 0, 2'd1, 24'h8);
    op(1, 1, 0, 4'd14, 0, 4'd0, 32'h1234, 0, 0, 0, 0, 24'hABCDEF);
    op(1, 2, 0, 4'd1, 32'd5, 4'd0, 32'h1234, 0, 0, 0, 0, 24'h10);
    op(1, 2, 0, 4'd1, 32'd0, 4'd0, 32'h1234, 0, 0, 0, 0, 24'h10);
    // R4 / R7: link in register form
    op(1, 1, 0, 4'd14, 0, 4'd15, 32'hFF12_3456, 0, 0, 0, 0, 24'h00_0100);
    // R5: count boundary values, both forms
    op(1, 2, 1, 4'd1, 32'd1, 4'd0, 0, 4'd15, 32'h40, 12'h004, 0, 24'h20);
    op(1, 2, 1, 4'd1, 32'd2, 4'd0, 0, 4'd15, 32'h40, 12'h004, 0, 24'h20);
    op(1, 2, 1, 4'd1, 32'd0, 4'd0, 0, 4'd15, 32'h40, 12'h004, 0, 24'h20);
    op(1, 2, 0, 4'd3, 32'd1, 4'd15, 32'h500, 0, 0, 0, 0, 24'h20);
    // R6: zero fields and wrap of the address sum
    op(1, 1, 1, 4'd14, 0, 4'd0, 32'hDEAD, 4'd0, 32'hBEEF, 12'hFFF, 0, 24'h30);
    op(1, 1, 1, 4'd14, 0, 4'd1, 32'hFFFF_FFFF, 4'd12, 32'h00FF_FFFF, 12'hFFF, 0, 24'h30);
    op(1, 1, 1, 4'd14, 0, 4'd1, 32'h0000_0010, 4'd0, 32'h7777, 12'h00A, 0, 24'h30);
    // R8: no-op class, and idle cycles
    op(1, 3, 1, 4'hF, 32'd9, 4'd4, 32'h100, 4'd5, 32'h100, 12'h1, 0, 24'h40);
    op(1, 3, 0, 4'hF, 32'd9, 4'd4, 32'h100, 0, 0, 0, 0, 24'h40);
    op(0, 1, 1, 4'd14, 32'd9, 4'd4, 32'h100, 4'd5, 32'h100, 12'h1, 0, 24'h40);
    op(0, 2, 0, 4'd14, 32'd9, 4'd4, 32'h100, 0, 0, 0, 0, 24'h40);
    // biased random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      logic [31:0] cv;
      r = $urandom;
      cv = (r[3:2] == 0) ? 32'(r[5:4]) : $urandom;
      op(r[31:30] != 0, 2'(r[7:6]), r[8],
         4'($urandom), cv,
         (r[10:9] == 0) ? 4'd0 : 4'($urandom), r[11] ? 32'hFFFF_FF00 | $urandom : $urandom,
         (r[13:12] == 0) ? 4'd0 : 4'($urandom), $urandom,
         12'($urandom), 2'($urandom), 24'($urandom));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule